// File: doc/BRIEF.md
# Symbol Timing Error Detector with Proportional-Integral Loop Filter

This block sits inside a symbol timing recovery loop. It receives matched-filter outputs at two samples per symbol. Each sample is tagged either as an on-time sample, taken at the expected symbol instant, or as a midpoint sample, taken halfway between two on-time samples. From these it forms one timing error per symbol. A fixed-point proportional-plus-integral loop filter then turns that error into a control word, which steers the interpolation counter that picks the next sampling phase.

One input selects the detector. The first choice is a decision-directed zero-crossing detector. It multiplies the midpoint sample by the difference of the hard sign decisions of the two surrounding on-time samples. The second choice is a non-data-aided Gardner detector. It multiplies the midpoint sample by the raw difference of those same two on-time samples. Both detectors feed the same loop filter, and that filter advances once per symbol. Its integrator carries guard bits and clamps at its limits instead of wrapping. A synchronous clear empties the sample history and the filter state.

Top module: `sym_timing_loop`

## Requirements
- R1: After reset, `err_vld` and `ctrl_vld` are 0, and `err_out` and `ctrl_out` are 0.
- R2: A midpoint sample (`samp_vld`=1, `on_time`=0) is only stored. It causes no `err_vld` pulse, and it leaves `err_out` and `ctrl_out` unchanged.
- R3: With `mode_gardner`=0, the error is m·(d_prev − d_cur). Here m is the last stored midpoint sample, and d is +1 for an on-time sample ≥ 0 and −1 for a negative one, so a sample of zero counts as +1. The error is therefore 0, +2m or −2m, and always even.
- R4: With `mode_gardner`=1, the error is m·(p − c). Here p is the previous on-time sample and c is the current one, and no sign function is applied.
- R5: `err_out` updates and `err_vld` pulses for exactly one cycle, in the cycle after an on-time strobe. `err_out` holds its value until the next on-time strobe.
- R6: In the cycle after each `err_vld` pulse, `ctrl_vld` pulses. `ctrl_out` equals (K_PROP·e)·2^(INT_FRAC−PROP_FRAC) plus the integrator value from before that update. In the same step the integrator adds K_INT·e. `ctrl_out` is expressed in units of 2^−INT_FRAC. Defaults: K_PROP=27892 with 22 fractional bits, K_INT=23781 with 30 fractional bits, both held as 16-bit values.
- R7: The IW-bit integrator saturates at 2^(IW−1)−1 and at −2^(IW−1). It never wraps.
- R8: `clr` sets to zero the stored midpoint sample, the previous on-time sample, the integrator and both outputs. It also drops any filter update that is pending in that cycle.
- R9: The detector mode is sampled with each on-time strobe, so a change of mode applies from the next error onward.
- R10: When `clr` and an on-time strobe arrive in the same cycle, the clear wins and no error is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of history and filter state |
| samp_vld | input | 1 | A sample is present on `samp` |
| on_time | input | 1 | 1: on-time sample, 0: midpoint sample |
| mode_gardner | input | 1 | 0: zero-crossing detector, 1: Gardner detector |
| samp | input | SW | Signed matched-filter sample |
| err_vld | output | 1 | One-cycle pulse marking a new timing error |
| err_out | output | 2·SW+1 | Signed raw timing error |
| ctrl_vld | output | 1 | One-cycle pulse marking a new control word |
| ctrl_out | output | CW | Signed loop filter output, in units of 2^−INT_FRAC |

## Verification
Two things share one clock edge whenever on-time strobes arrive in back-to-back cycles. At that edge the filter is updating with the error of symbol k while the detector is forming the error of symbol k+1. The scoreboard checks each control word against a model that uses the integrator value from before its own update.

The clear can also land on the same edge as other work. The bench drives `clr` together with an on-time strobe, and again in the cycle where an error is waiting for the filter. In both cases it expects no result, zeroed outputs, and a next symbol whose result shows that both the history and the integrator started again from zero.

// File: rtl/sym_timing_pkg.sv
package sym_timing_pkg;

    typedef enum logic {
        DET_ZERO_CROSS = 1'b0,
        DET_GARDNER    = 1'b1
    } det_mode_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sym_ted_stage.sv
module sym_ted_stage
    import sym_timing_pkg::*;
#(
    parameter int SW = 12,
    parameter int EW = 2 * SW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 samp_vld,
    input  logic                 on_time,
    input  det_mode_e            mode,
    input  logic signed [SW-1:0] samp,
    output logic signed [EW-1:0] err,
    output logic                 err_vld
);

    typedef struct packed {
        logic signed [SW-1:0] mid;
        logic signed [SW-1:0] prev;
        logic signed [EW-1:0] err;
        logic                 vld;
    } ted_st_t;

    ted_st_t st_d, st_q;

    logic signed [EW-1:0] mid_x;
    logic signed [SW:0]   diff;
    logic signed [EW-1:0] diff_x;
    logic signed [EW-1:0] err_gd;
    logic signed [EW-1:0] err_zc;

    always_comb begin
        mid_x  = {{(EW-SW){st_q.mid[SW-1]}}, st_q.mid};
        diff   = {st_q.prev[SW-1], st_q.prev} - {samp[SW-1], samp};
        diff_x = {{(EW-SW-1){diff[SW]}}, diff};
        err_gd = mid_x * diff_x;

        // decisions: a sign bit of 0 (including zero) means +1
        if (st_q.prev[SW-1] == samp[SW-1]) begin
            err_zc = '0;
        end else if (!st_q.prev[SW-1]) begin
            err_zc = mid_x <<< 1;
        end else begin
            err_zc = -(mid_x <<< 1);
        end

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clr) begin
            st_d = '0;
        end else if (samp_vld) begin
            if (on_time) begin
                st_d.err  = (mode == DET_GARDNER) ? err_gd : err_zc;
                st_d.vld  = 1'b1;
                st_d.prev = samp;
            end else begin
                st_d.mid = samp;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err     = st_q.err;
    assign err_vld = st_q.vld;

endmodule

// File: rtl/sym_pi_stage.sv
module sym_pi_stage #(
    parameter int            EW      = 25,
    parameter int            KW      = 16,
    parameter logic [KW-1:0] K_PROP  = 16'd27892,
    parameter logic [KW-1:0] K_INT   = 16'd23781,
    parameter int            SH      = 8,
    parameter int            IW      = 44,
    parameter int            CW      = 51
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 err_vld,
    input  logic signed [EW-1:0] err,
    output logic signed [CW-1:0] ctrl,
    output logic                 ctrl_vld
);

    localparam int PW = EW + KW + 1;

    typedef struct packed {
        logic signed [IW-1:0] integ;
        logic signed [CW-1:0] ctrl;
        logic                 vld;
    } pi_st_t;

    pi_st_t st_d, st_q;

    logic signed [PW-1:0] err_x;
    logic signed [PW-1:0] kp_x;
    logic signed [PW-1:0] ki_x;
    logic signed [PW-1:0] p_prop;
    logic signed [PW-1:0] p_int;
    logic signed [IW:0]   sum;
    logic signed [IW-1:0] sat;
    logic signed [CW-1:0] ctrl_n;

    always_comb begin
        err_x  = {{(PW-EW){err[EW-1]}}, err};
        kp_x   = {{(PW-KW){1'b0}}, K_PROP};
        ki_x   = {{(PW-KW){1'b0}}, K_INT};
        p_prop = err_x * kp_x;
        p_int  = err_x * ki_x;

        sum = {{(IW+1-PW){p_int[PW-1]}}, p_int} + {st_q.integ[IW-1], st_q.integ};
        if (sum[IW] != sum[IW-1]) begin
            sat = sum[IW] ? {1'b1, {(IW-1){1'b0}}} : {1'b0, {(IW-1){1'b1}}};
        end else begin
            sat = sum[IW-1:0];
        end

        ctrl_n = {{(CW-PW-SH){p_prop[PW-1]}}, p_prop, {SH{1'b0}}}
               + {{(CW-IW){st_q.integ[IW-1]}}, st_q.integ};

        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clr) begin
            st_d = '0;
        end else if (err_vld) begin
            st_d.integ = sat;
            st_d.ctrl  = ctrl_n;
            st_d.vld   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl     = st_q.ctrl;
    assign ctrl_vld = st_q.vld;

endmodule

// File: rtl/sym_timing_loop.sv
module sym_timing_loop
    import sym_timing_pkg::*;
#(
    parameter int            SW        = 12,
    parameter int            KW        = 16,
    parameter logic [KW-1:0] K_PROP    = 16'd27892,
    parameter logic [KW-1:0] K_INT     = 16'd23781,
    parameter int            PROP_FRAC = 22,
    parameter int            INT_FRAC  = 30,
    parameter int            IW        = 44,
    localparam int           EW        = 2 * SW + 1,
    localparam int           SH        = INT_FRAC - PROP_FRAC,
    localparam int           PW        = EW + KW + 1,
    localparam int           CW        = imax(PW + SH, IW) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 samp_vld,
    input  logic                 on_time,
    input  logic                 mode_gardner,
    input  logic signed [SW-1:0] samp,
    output logic                 err_vld,
    output logic signed [EW-1:0] err_out,
    output logic                 ctrl_vld,
    output logic signed [CW-1:0] ctrl_out
);

    det_mode_e mode;
    assign mode = det_mode_e'(mode_gardner);

    sym_ted_stage #(
        .SW (SW),
        .EW (EW)
    ) u_ted (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .samp_vld (samp_vld),
        .on_time  (on_time),
        .mode     (mode),
        .samp     (samp),
        .err      (err_out),
        .err_vld  (err_vld)
    );

    sym_pi_stage #(
        .EW     (EW),
        .KW     (KW),
        .K_PROP (K_PROP),
        .K_INT  (K_INT),
        .SH     (SH),
        .IW     (IW),
        .CW     (CW)
    ) u_pi (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .err_vld  (err_vld),
        .err      (err_out),
        .ctrl     (ctrl_out),
        .ctrl_vld (ctrl_vld)
    );

endmodule

// File: rtl/sym_timing_loop_chk.sv
module sym_timing_loop_chk #(
    parameter int EW = 25,
    parameter int CW = 51
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 clr,
    input logic                 samp_vld,
    input logic                 on_time,
    input logic                 mode_gardner,
    input logic                 err_vld,
    input logic signed [EW-1:0] err_out,
    input logic                 ctrl_vld,
    input logic signed [CW-1:0] ctrl_out
);

    assert_err_follows_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_vld && on_time && !clr) |=> err_vld);

    assert_no_err_without_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(samp_vld && on_time) || clr) |=> !err_vld);

    assert_err_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(samp_vld && on_time) && !clr) |=> $stable(err_out));

    assert_ctrl_after_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld && !clr) |=> ctrl_vld);

    assert_ctrl_only_after_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_vld || clr) |=> !ctrl_vld);

    assert_zc_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_vld && on_time && !clr && !mode_gardner) |=> !err_out[0]);

    assert_clear_zeroes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!err_vld && !ctrl_vld && err_out == '0 && ctrl_out == '0));

endmodule

bind sym_timing_loop sym_timing_loop_chk #(.EW(EW), .CW(CW)) u_chk (.*);

// File: tb/sym_timing_loop_bench.sv
module sym_timing_loop_bench;

    localparam int SW = 12;
    localparam int EW = 2 * SW + 1;
    localparam int CW = 51;
    localparam longint K1 = 27892;
    localparam longint K2 = 23781;
    localparam longint SCALE = 256;
    localparam longint IMAX = (longint'(1) <<< 43) - 1;
    localparam longint IMIN = -(longint'(1) <<< 43);

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic                 rst_n = 1'b0;
    logic                 clr = 1'b0;
    logic                 samp_vld = 1'b0;
    logic                 on_time = 1'b0;
    logic                 mode_gardner = 1'b0;
    logic signed [SW-1:0] samp = '0;
    logic                 err_vld;
    logic signed [EW-1:0] err_out;
    logic                 ctrl_vld;
    logic signed [CW-1:0] ctrl_out;

    sym_timing_loop u_sym_timing_loop (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (clr),
        .samp_vld     (samp_vld),
        .on_time      (on_time),
        .mode_gardner (mode_gardner),
        .samp         (samp),
        .err_vld      (err_vld),
        .err_out      (err_out),
        .ctrl_vld     (ctrl_vld),
        .ctrl_out     (ctrl_out)
    );

    int n_cmp = 0;
    int n_bad = 0;

    longint q_err[$];
    longint q_ctrl[$];
    string  q_tag[$];
    string  q_ctag[$];

    longint m_mid = 0, m_prev = 0, m_integ = 0;
    longint m_last_err = 0, m_last_ctrl = 0;

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic longint clamp(input longint v);
        if (v > IMAX) return IMAX;
        if (v < IMIN) return IMIN;
        return v;
    endfunction

    // scoreboard monitor
    logic last_ev = 1'b0;
    always @(posedge clk) begin
        longint act, exp;
        string  tg;
        #1;
        if (rst_n) begin
            if (err_vld) begin
                act = longint'(err_out);
                if (q_err.size() == 0) begin
                    check(1'b0, "R5 unexpected err_vld", act, 0);
                end else begin
                    exp = q_err.pop_front();
                    tg  = q_tag.pop_front();
                    check(act == exp, tg, act, exp);
                end
            end
            if (ctrl_vld) begin
                act = longint'(ctrl_out);
                check(last_ev, "R6 ctrl_vld one cycle after err_vld", 0, 1);
                if (q_ctrl.size() == 0) begin
                    check(1'b0, "R6 unexpected ctrl_vld", act, 0);
                end else begin
                    exp = q_ctrl.pop_front();
                    tg  = q_ctag.pop_front();
                    check(act == exp, tg, act, exp);
                end
            end
            last_ev = err_vld;
        end
    end

    // driver: entered at a falling edge, leaves at the next one
    task automatic drive(input bit ot, input int v, input bit g, input bit c);
        samp_vld     = 1'b1;
        on_time      = ot;
        samp         = v[SW-1:0];
        mode_gardner = g;
        clr          = c;
        @(negedge clk);
        samp_vld = 1'b0;
        on_time  = 1'b0;
        clr      = 1'b0;
    endtask

    task automatic send_mid(input int v);
        m_mid = v;
        drive(1'b0, v, 1'b0, 1'b0);
    endtask

    task automatic send_on(input int v, input bit g, input string tag, input bit keep_ctrl = 1'b1);
        longint e, dp, dc;
        if (g) begin
            e = m_mid * (m_prev - longint'(v));
        end else begin
            dp = (m_prev < 0) ? -1 : 1;
            dc = (v < 0) ? -1 : 1;
            e  = m_mid * (dp - dc);
        end
        q_err.push_back(e);
        q_tag.push_back(tag);
        m_last_err = e;
        if (keep_ctrl) begin
            m_last_ctrl = K1 * e * SCALE + m_integ;
            q_ctrl.push_back(m_last_ctrl);
            q_ctag.push_back({tag, " R6 ctrl"});
            m_integ = clamp(m_integ + K2 * e);
        end
        m_prev = v;
        drive(1'b1, v, g, 1'b0);
    endtask

    task automatic send_clear();
        samp_vld = 1'b0;
        clr      = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        m_mid = 0; m_prev = 0; m_integ = 0;
        m_last_err = 0; m_last_ctrl = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(8 * 100000);
        check(1'b0, "watchdog expired", 0, 1);
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        idle(3);
        check(err_vld == 1'b0 && ctrl_vld == 1'b0, "R1 valids low in reset", {err_vld, ctrl_vld}, 0);
        check(err_out == '0, "R1 err_out zero in reset", longint'(err_out), 0);
        rst_n = 1'b1;
        idle(2);
        check(ctrl_out == '0, "R1 ctrl_out zero after reset", longint'(ctrl_out), 0);

        // R3: zero-crossing detector
        send_mid(300);  send_on(500, 1'b0, "R3 same sign zero");
        send_mid(-700); send_on(-200, 1'b0, "R3 pos to neg +2m");
        send_mid(400);  send_on(600, 1'b0, "R3 neg to pos -2m");
        send_mid(-123); send_on(-50, 1'b0, "R3 pos to neg negative m");
        send_mid(77);   send_on(0, 1'b0, "R3 zero counts as +1");
        idle(3);

        // R4: Gardner detector
        send_mid(-2048); send_on(2047, 1'b1, "R4 full product");
        send_mid(1000);  send_on(-1500, 1'b1, "R4 negative step");
        send_mid(-33);   send_on(-1500, 1'b1, "R4 equal samples");
        send_mid(5);     send_on(12, 1'b1, "R4 small values");
        idle(3);

        // R2: midpoints only are stored
        send_mid(1000); send_mid(-1000); send_mid(5);
        idle(4);
        check(longint'(err_out) == m_last_err, "R2 err_out unchanged by midpoints",
              longint'(err_out), m_last_err);
        check(longint'(ctrl_out) == m_last_ctrl, "R2 ctrl_out unchanged by midpoints",
              longint'(ctrl_out), m_last_ctrl);
        send_on(-7, 1'b1, "R2 last midpoint used");

        // R6: back-to-back on-time strobes overlap filter and detector
        send_mid(900);
        send_on(300, 1'b1, "R6 back-to-back a");
        send_on(-800, 1'b1, "R6 back-to-back b");
        send_on(100, 1'b1, "R6 back-to-back c");
        idle(3);

        // R9: mode sampled per strobe
        send_mid(500);
        send_on(-300, 1'b1, "R9 gardner then");
        send_on(300, 1'b0, "R9 zero-crossing now");
        idle(3);

        // R10: clear together with a strobe
        drive(1'b1, 999, 1'b1, 1'b1);
        m_mid = 0; m_prev = 0; m_integ = 0; m_last_err = 0; m_last_ctrl = 0;
        idle(2);
        check(err_out == '0, "R10 clear beats strobe err_out", longint'(err_out), 0);
        check(ctrl_out == '0, "R10 clear beats strobe ctrl_out", longint'(ctrl_out), 0);

        // R8: clear in the cycle a filter update is pending
        send_mid(100);
        send_on(-100, 1'b1, "R8 error before clear", 1'b0);
        send_clear();
        idle(2);
        check(ctrl_out == '0, "R8 pending update dropped", longint'(ctrl_out), 0);
        send_mid(10);
        send_on(-5, 1'b0, "R8 previous sample cleared");
        idle(3);

        // R7: positive saturation
        send_mid(0); send_on(2047, 1'b1, "R7 preset");
        for (int i = 0; i < 60; i++) begin
            if (i % 2 == 0) begin send_mid(2047);  send_on(-2048, 1'b1, "R7 ramp up"); end
            else            begin send_mid(-2048); send_on(2047, 1'b1, "R7 ramp up"); end
        end
        send_mid(0); send_on(0, 1'b1, "R7 read integrator");
        idle(3);
        check(longint'(ctrl_out) == IMAX, "R7 integrator at positive limit", longint'(ctrl_out), IMAX);

        // R7: negative saturation
        for (int i = 0; i < 120; i++) begin
            if (i % 2 == 0) begin send_mid(-2048); send_on(-2048, 1'b1, "R7 ramp down"); end
            else            begin send_mid(2047);  send_on(2047, 1'b1, "R7 ramp down"); end
        end
        send_mid(0); send_on(0, 1'b1, "R7 read integrator low");
        idle(3);
        check(longint'(ctrl_out) == IMIN, "R7 integrator at negative limit", longint'(ctrl_out), IMIN);

        idle(5);
        check(q_err.size() == 0 && q_ctrl.size() == 0, "R6 all results delivered",
              q_err.size() + q_ctrl.size(), 0);
        summary();
        $finish;
    end

endmodule